// File: doc/BRIEF.md
# Framebuffer Rectangle Fill and Copy Engine

This block is a small blitter for a byte-addressed framebuffer. Software-side logic hands it one request at a time: a solid fill of a rectangle, a copy of one rectangle to another place on the same surface, an update notice for a rectangle written elsewhere, or a flush. Surface width, height, line stride and bytes per pixel come in as configuration inputs. Pixel `(x, y)` starts at byte address `bpp * x + stride * y`. The engine moves one byte per cycle through a single-port synchronous RAM with a one-cycle read latency.

Each rectangle is checked against the surface before anything is done with it. A fill or copy that passes is carried out and its destination rectangle is appended to a dirty-rectangle ring. A flush either drains the ring in order onto the update output, one rectangle per cycle, or discards the whole ring in one step when the display is marked invalidated. Overlapping copies are safe. The vertical direction is chosen from the two row coordinates, and the horizontal byte order is chosen from the two column coordinates.

The controller is one state machine. `IDLE` accepts a request. A fill, copy or update goes to `CHECK`. A flush goes to `FLUSH`, or straight to `DONE` when invalidated is high. `CHECK` goes to `DONE` on a rejected fill or copy. It goes to `PUSH` for an update or a zero-sized rectangle. Otherwise it goes to `FILL0` for a fill or to `RD` for a copy. `FILL0` writes the first fill row and then goes to `RD`, or to `PUSH` for a one-row fill. `RD` always goes to `WR`. `WR` returns to `RD` until the last byte of the last row, then goes to `PUSH`. `PUSH` goes to `DONE`. `FLUSH` stays until the ring is empty, then goes to `DONE`. `DONE` returns to `IDLE`.

Top module: `blit_engine`

## Requirements
- R1: A rectangle fails the check if any of these holds:
  - x, y, w or h is negative (two's complement).
  - x or w exceeds MAX_W, which defaults to 2368.
  - y or h exceeds MAX_H, which defaults to 1770.
  - x + w exceeds the surface width.
  - y + h exceeds the surface height.
  A fill that fails ends with `err` = 1 one cycle after acceptance and makes no memory write.
- R2: A copy is rejected with `err` = 1 and no memory access when either its source or its destination rectangle fails the R1 check.
- R3: The byte address of pixel (x, y) is bpp·x + stride·y. Byte i of a row lies at that row's start address plus i.
- R4: A fill sends the 32-bit colour least-significant byte first, repeating its low bpp bytes across the first row. Every later row is a copy of the first row.
- R5: For a copy, the vertical order depends on the rows:
  - When the destination y exceeds the source y, rows are processed from the last upward.
  - Otherwise rows are processed from the first downward.
  - When the destination x exceeds the source x, bytes within a row go right to left.
  The result always equals a copy taken from the unmodified source.
- R6: A successful fill or copy, including one with w or h equal to 0, appends its destination rectangle to the dirty ring. `done` comes with `err` = 0.
- R7: The ring holds RING_DEPTH (512) entries. Its write index wraps with no full check, so after RING_DEPTH+1 appends from an empty ring, a flush yields only the newest rectangle.
- R8: A flush with `invalidated` = 1 empties the ring at once and emits nothing. `done` appears in the cycle after acceptance, and a later flush also emits nothing.
- R9: A flush with `invalidated` = 0 emits the stored rectangles oldest first on `upd_valid`, one per cycle, starting in the cycle after acceptance. `done` follows one idle cycle after the last one.
- R10: An update request (op 2) always succeeds. A rectangle that passes the check is appended as given, and one that fails is replaced by (0, 0, surface width, surface height).
- R11: A fill or copy while `cfg_bpp` is outside 1 to 4 is rejected with `err` = 1 and no memory write.
- R12: Request opcodes are 0 fill, 1 copy, 2 update and 3 flush.
  - A request is taken only while `busy` is low.
  - `busy` stays high from acceptance through a one-cycle `done` pulse.
  - A request held high while busy is ignored.
  - A memory read is always followed in the next cycle by the write that uses its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_surf_w | input | 16 | Surface width in pixels |
| cfg_surf_h | input | 16 | Surface height in pixels |
| cfg_stride | input | STRIDE_W | Bytes per surface line |
| cfg_bpp | input | 3 | Bytes per pixel, legal 1 to 4 |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_op | input | 2 | 0 fill, 1 copy, 2 update, 3 flush |
| req_colour | input | 32 | Fill colour, low byte first |
| req_x | input | 16 | Destination x (signed) |
| req_y | input | 16 | Destination y (signed) |
| req_src_x | input | 16 | Copy source x (signed) |
| req_src_y | input | 16 | Copy source y (signed) |
| req_w | input | 16 | Width in pixels (signed) |
| req_h | input | 16 | Height in rows (signed) |
| invalidated | input | 1 | Sampled with a flush request; discards the ring |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Rejection status, valid with done |
| upd_valid | output | 1 | Dirty rectangle on the upd outputs |
| upd_x | output | 16 | Dirty rectangle x |
| upd_y | output | 16 | Dirty rectangle y |
| upd_w | output | 16 | Dirty rectangle width |
| upd_h | output | 16 | Dirty rectangle height |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM byte address |
| mem_wdata | output | 8 | RAM write byte |
| mem_rdata | input | 8 | RAM read byte, one cycle after the read |

## Verification
Latency is counted in clock edges after the edge that accepts the request, where nb is bpp·w:

| Result | `done` after |
|---|---|
| Rejection | 1 edge |
| Update or zero-sized operation | 2 edges |
| Fill | 2 + nb + 2·nb·(h−1) edges |
| Copy | 2 + 2·nb·h edges |
| Invalidated flush | 0 edges (the cycle right after acceptance) |

A normal flush presents its k-th rectangle k−1 edges after acceptance, and its `done` arrives k+1 edges after acceptance. The driver records the acceptance cycle before it raises the request. Each expected item carries its due latency. The monitor samples on the falling edge and fails any result whose latency, fields or status differ from the item at the head of the queue. Memory contents are compared with an independent byte model after every operation.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int BLT_CW = 16;

    typedef enum logic [1:0] {
        OP_FILL   = 2'd0,
        OP_COPY   = 2'd1,
        OP_UPDATE = 2'd2,
        OP_FLUSH  = 2'd3
    } blit_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_FILL0,
        S_RD,
        S_WR,
        S_PUSH,
        S_FLUSH,
        S_DONE
    } blit_state_e;

    typedef struct packed {
        logic signed [BLT_CW-1:0] x;
        logic signed [BLT_CW-1:0] y;
        logic signed [BLT_CW-1:0] w;
        logic signed [BLT_CW-1:0] h;
    } blit_rect_t;

endpackage

// File: rtl/blit_rect_check.sv
module blit_rect_check #(
    parameter int CW    = 16,
    parameter int MAX_W = 2368,
    parameter int MAX_H = 1770
) (
    input  logic signed [CW-1:0] x,
    input  logic signed [CW-1:0] y,
    input  logic signed [CW-1:0] w,
    input  logic signed [CW-1:0] h,
    input  logic        [CW-1:0] surf_w,
    input  logic        [CW-1:0] surf_h,
    output logic                 ok
);
    localparam int EW = CW + 2;
    localparam logic signed [EW-1:0] LIM_W = EW'(MAX_W);
    localparam logic signed [EW-1:0] LIM_H = EW'(MAX_H);

    logic signed [EW-1:0] xe, ye, we, he, sw, sh, x_end, y_end;

    always_comb begin
        xe    = $signed({{2{x[CW-1]}}, x});
        ye    = $signed({{2{y[CW-1]}}, y});
        we    = $signed({{2{w[CW-1]}}, w});
        he    = $signed({{2{h[CW-1]}}, h});
        sw    = $signed({2'b00, surf_w});
        sh    = $signed({2'b00, surf_h});
        x_end = xe + we;
        y_end = ye + he;
        ok    = !((xe < 0) || (xe > LIM_W) || (we < 0) || (we > LIM_W) || (x_end > sw) ||
                  (ye < 0) || (ye > LIM_H) || (he < 0) || (he > LIM_H) || (y_end > sh));
    end
endmodule

// File: rtl/blit_dirty_ring.sv
module blit_dirty_ring
    import blit_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  blit_rect_t push_rect,
    input  logic       pop,
    input  logic       clear,
    output blit_rect_t head,
    output logic       empty
);
    localparam int IW = $clog2(DEPTH);

    blit_rect_t     slots [DEPTH];
    logic [IW-1:0]  wr_idx, rd_idx;

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_idx] <= push_rect;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
        end else begin
            if (push) begin
                wr_idx <= wr_idx + IW'(1);
            end
            if (clear) begin
                rd_idx <= wr_idx;
            end else if (pop) begin
                rd_idx <= rd_idx + IW'(1);
            end
        end
    end

    assign head  = slots[rd_idx];
    assign empty = (rd_idx == wr_idx);

    assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !push) |=> empty);
endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int STRIDE_W   = 16,
    parameter int MAX_W      = 2368,
    parameter int MAX_H      = 1770,
    parameter int RING_DEPTH = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BLT_CW-1:0]   cfg_surf_w,
    input  logic [BLT_CW-1:0]   cfg_surf_h,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [2:0]          cfg_bpp,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [31:0]         req_colour,
    input  logic [BLT_CW-1:0]   req_x,
    input  logic [BLT_CW-1:0]   req_y,
    input  logic [BLT_CW-1:0]   req_src_x,
    input  logic [BLT_CW-1:0]   req_src_y,
    input  logic [BLT_CW-1:0]   req_w,
    input  logic [BLT_CW-1:0]   req_h,
    input  logic                invalidated,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic                upd_valid,
    output logic [BLT_CW-1:0]   upd_x,
    output logic [BLT_CW-1:0]   upd_y,
    output logic [BLT_CW-1:0]   upd_w,
    output logic [BLT_CW-1:0]   upd_h,
    output logic                mem_en,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [7:0]          mem_wdata,
    input  logic [7:0]          mem_rdata
);
    localparam int CW = BLT_CW;
    localparam int BW = $clog2(4 * MAX_W + 1);
    localparam int AW = ADDR_W;

    blit_state_e state, nstate;

    blit_op_e              r_op;
    logic [31:0]           r_col;
    logic signed [CW-1:0]  r_x, r_y, r_sx, r_sy, r_w, r_h;
    logic                  r_err, r_full, r_rrow, r_rcol;
    logic [BW-1:0]         r_nb, col_off;
    logic [CW-1:0]         row_off;
    logic [1:0]            cb;

    // bounds checks: index 0 destination, index 1 source
    logic [1:0]            chk_ok;
    logic signed [CW-1:0]  chk_x [2];
    logic signed [CW-1:0]  chk_y [2];

    assign chk_x[0] = r_x;
    assign chk_y[0] = r_y;
    assign chk_x[1] = r_sx;
    assign chk_y[1] = r_sy;

    for (genvar gi = 0; gi < 2; gi++) begin : g_chk
        blit_rect_check #(.CW(CW), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_chk (
            .x      (chk_x[gi]),
            .y      (chk_y[gi]),
            .w      (r_w),
            .h      (r_h),
            .surf_w (cfg_surf_w),
            .surf_h (cfg_surf_h),
            .ok     (chk_ok[gi])
        );
    end

    logic           bpp_ok, mem_ok, zero_sz, col_last, row_last, is_copy;
    logic [BW-1:0]  nb_calc;
    logic [CW-1:0]  h_last;

    always_comb begin
        is_copy  = (r_op == OP_COPY);
        bpp_ok   = (cfg_bpp != 3'd0) && (cfg_bpp <= 3'd4);
        mem_ok   = bpp_ok && chk_ok[0] && (!is_copy || chk_ok[1]);
        nb_calc  = BW'(cfg_bpp) * BW'($unsigned(r_w));
        zero_sz  = (nb_calc == '0) || (r_h == '0);
        h_last   = $unsigned(r_h) - CW'(1);
        col_last = r_rcol ? (col_off == '0) : (col_off == r_nb - BW'(1));
        row_last = r_rrow ? (row_off == '0) : (row_off == h_last);
    end

    // byte addresses
    logic [AW-1:0] src_col, src_row, dst_addr, src_addr;

    always_comb begin
        src_col  = (r_op == OP_FILL) ? AW'($unsigned(r_x)) : AW'($unsigned(r_sx));
        src_row  = (r_op == OP_FILL) ? AW'($unsigned(r_y)) : AW'($unsigned(r_sy)) + AW'(row_off);
        dst_addr = AW'(cfg_bpp) * AW'($unsigned(r_x))
                 + AW'(cfg_stride) * (AW'($unsigned(r_y)) + AW'(row_off))
                 + AW'(col_off);
        src_addr = AW'(cfg_bpp) * src_col + AW'(cfg_stride) * src_row + AW'(col_off);
    end

    // dirty ring
    logic       ring_push, ring_pop, ring_clear, ring_empty;
    blit_rect_t ring_in, ring_head;

    always_comb begin
        if (r_full && r_op == OP_UPDATE) begin
            ring_in = '{x: '0, y: '0, w: $signed(cfg_surf_w), h: $signed(cfg_surf_h)};
        end else begin
            ring_in = '{x: r_x, y: r_y, w: r_w, h: r_h};
        end
    end

    blit_dirty_ring #(.DEPTH(RING_DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ring_push),
        .push_rect (ring_in),
        .pop       (ring_pop),
        .clear     (ring_clear),
        .head      (ring_head),
        .empty     (ring_empty)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    if (blit_op_e'(req_op) == OP_FLUSH) begin
                        nstate = invalidated ? S_DONE : S_FLUSH;
                    end else begin
                        nstate = S_CHECK;
                    end
                end
            end
            S_CHECK: begin
                if (r_op == OP_UPDATE)  nstate = S_PUSH;
                else if (!mem_ok)       nstate = S_DONE;
                else if (zero_sz)       nstate = S_PUSH;
                else if (!is_copy)      nstate = S_FILL0;
                else                    nstate = S_RD;
            end
            S_FILL0: begin
                if (col_last) nstate = (r_h == CW'(1)) ? S_PUSH : S_RD;
            end
            S_RD:    nstate = S_WR;
            S_WR: begin
                if (col_last) nstate = row_last ? S_PUSH : S_RD;
                else          nstate = S_RD;
            end
            S_PUSH:  nstate = S_DONE;
            S_FLUSH: begin
                if (ring_empty) nstate = S_DONE;
            end
            S_DONE:  nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    // request and walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_op    <= OP_FILL;
            r_col   <= '0;
            r_x     <= '0;
            r_y     <= '0;
            r_sx    <= '0;
            r_sy    <= '0;
            r_w     <= '0;
            r_h     <= '0;
            r_err   <= 1'b0;
            r_full  <= 1'b0;
            r_rrow  <= 1'b0;
            r_rcol  <= 1'b0;
            r_nb    <= '0;
            col_off <= '0;
            row_off <= '0;
            cb      <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        r_op  <= blit_op_e'(req_op);
                        r_col <= req_colour;
                        r_x   <= $signed(req_x);
                        r_y   <= $signed(req_y);
                        r_sx  <= $signed(req_src_x);
                        r_sy  <= $signed(req_src_y);
                        r_w   <= $signed(req_w);
                        r_h   <= $signed(req_h);
                        r_err <= 1'b0;
                    end
                end
                S_CHECK: begin
                    r_nb    <= nb_calc;
                    r_err   <= (r_op != OP_UPDATE) && !mem_ok;
                    r_full  <= !chk_ok[0];
                    r_rrow  <= is_copy && (r_y > r_sy);
                    r_rcol  <= is_copy && (r_x > r_sx);
                    row_off <= (is_copy && (r_y > r_sy)) ? h_last : '0;
                    col_off <= (is_copy && (r_x > r_sx)) ? nb_calc - BW'(1) : '0;
                    cb      <= '0;
                end
                S_FILL0: begin
                    if (col_last) begin
                        row_off <= CW'(1);
                        col_off <= '0;
                    end else begin
                        col_off <= col_off + BW'(1);
                        cb      <= ({1'b0, cb} == cfg_bpp - 3'd1) ? 2'd0 : cb + 2'd1;
                    end
                end
                S_WR: begin
                    if (col_last) begin
                        row_off <= r_rrow ? row_off - CW'(1) : row_off + CW'(1);
                        col_off <= r_rcol ? r_nb - BW'(1) : '0;
                    end else begin
                        col_off <= r_rcol ? col_off - BW'(1) : col_off + BW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state != S_IDLE);
        done       = 1'b0;
        err        = 1'b0;
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = dst_addr;
        mem_wdata  = mem_rdata;
        ring_push  = 1'b0;
        ring_pop   = 1'b0;
        ring_clear = (state == S_IDLE) && req_valid &&
                     (blit_op_e'(req_op) == OP_FLUSH) && invalidated;
        upd_valid  = 1'b0;
        unique case (state)
            S_FILL0: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = r_col[8*cb +: 8];
            end
            S_RD: begin
                mem_en   = 1'b1;
                mem_addr = src_addr;
            end
            S_WR: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
            end
            S_PUSH:  ring_push = 1'b1;
            S_FLUSH: begin
                upd_valid = !ring_empty;
                ring_pop  = !ring_empty;
            end
            S_DONE: begin
                done = 1'b1;
                err  = r_err;
            end
            default: ;
        endcase
        upd_x = ring_head.x;
        upd_y = ring_head.y;
        upd_w = ring_head.w;
        upd_h = ring_head.h;
    end

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_at_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_read_then_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (mem_en && mem_we));
    assert_no_mem_in_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> !mem_en);
    assert_inval_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_op == 2'd3 && invalidated) |=> (done && !upd_valid));
endmodule

// File: tb/blit_engine_tb.sv
module blit_engine_tb;
    localparam int STRIDE = 40;
    localparam int SW = 8;
    localparam int SH = 8;
    localparam int WD_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_bpp = 3'd1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_colour = '0;
    logic [15:0] req_x = '0, req_y = '0, req_src_x = '0, req_src_y = '0, req_w = '0, req_h = '0;
    logic        invalidated = 1'b0;
    logic        busy, done, err, upd_valid, mem_en, mem_we;
    logic [15:0] upd_x, upd_y, upd_w, upd_h;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    always #10 clk = ~clk;

    blit_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_surf_w(16'(SW)), .cfg_surf_h(16'(SH)), .cfg_stride(16'(STRIDE)), .cfg_bpp(cfg_bpp),
        .req_valid(req_valid), .req_op(req_op), .req_colour(req_colour),
        .req_x(req_x), .req_y(req_y), .req_src_x(req_src_x), .req_src_y(req_src_y),
        .req_w(req_w), .req_h(req_h), .invalidated(invalidated),
        .busy(busy), .done(done), .err(err),
        .upd_valid(upd_valid), .upd_x(upd_x), .upd_y(upd_y), .upd_w(upd_w), .upd_h(upd_h),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // framebuffer RAM model
    logic [7:0] fb [0:511];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) fb[i] <= 8'(i * 7 + 3);
        end else if (mem_en) begin
            if (mem_we) fb[mem_addr[8:0]] <= mem_wdata;
            mem_rdata <= fb[mem_addr[8:0]];
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    kind;  // 0 done, 1 update
        int    err;
        int    x, y, w, h;
        int    lat;
        string tag;
    } exp_t;

    typedef struct { int x, y, w, h; } rect_t;

    exp_t       q[$];
    rect_t      pend[$];
    int         acc_cyc = 0;
    logic [7:0] ref_fb [0:511];
    int         mon_checks = 0, mon_fails = 0;
    int         drv_checks = 0, drv_fails = 0;

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                mon_checks++;
                if (q.size() == 0) begin
                    mon_fails++;
                    $display("FAIL R12 unexpected done: actual err=%0d expected none", err);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.kind != 0 || int'(err) != e.err || cyc - acc_cyc != e.lat) begin
                        mon_fails++;
                        $display("FAIL %s done: actual err=%0d lat=%0d expected kind=%0d err=%0d lat=%0d",
                                 e.tag, err, cyc - acc_cyc, e.kind, e.err, e.lat);
                    end
                end
            end
            if (upd_valid) begin
                mon_checks++;
                if (q.size() == 0) begin
                    mon_fails++;
                    $display("FAIL R9 unexpected update: actual (%0d,%0d,%0d,%0d) expected none",
                             $signed(upd_x), $signed(upd_y), $signed(upd_w), $signed(upd_h));
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.kind != 1 || int'($signed(upd_x)) != e.x || int'($signed(upd_y)) != e.y ||
                        int'($signed(upd_w)) != e.w || int'($signed(upd_h)) != e.h ||
                        cyc - acc_cyc != e.lat) begin
                        mon_fails++;
                        $display("FAIL %s update: actual (%0d,%0d,%0d,%0d) lat=%0d expected kind=%0d (%0d,%0d,%0d,%0d) lat=%0d",
                                 e.tag, $signed(upd_x), $signed(upd_y), $signed(upd_w), $signed(upd_h),
                                 cyc - acc_cyc, e.kind, e.x, e.y, e.w, e.h, e.lat);
                    end
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc == WD_LIMIT) begin
            $display("FAIL watchdog: actual cycle=%0d expected completion before it", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures",
                     mon_checks + drv_checks + 1, mon_fails + drv_fails + 1);
            $finish;
        end
    end

    task automatic exp_done(int e_err, int lat, string tag);
        exp_t e;
        e.kind = 0; e.err = e_err; e.x = 0; e.y = 0; e.w = 0; e.h = 0; e.lat = lat; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic exp_upd(rect_t r, int lat, string tag);
        exp_t e;
        e.kind = 1; e.err = 0; e.x = r.x; e.y = r.y; e.w = r.w; e.h = r.h; e.lat = lat; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic do_op(int op, int col, int x, int y, int sx, int sy, int w, int h, bit inv, int linger);
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid  = 1'b1;
        req_op     = 2'(op);
        req_colour = col;
        req_x = 16'(x); req_y = 16'(y); req_src_x = 16'(sx); req_src_y = 16'(sy);
        req_w = 16'(w); req_h = 16'(h);
        invalidated = inv;
        acc_cyc = cyc + 1;
        @(negedge clk);
        if (linger > 0) begin
            req_op = 2'd2;
            repeat (linger) @(negedge clk);
        end
        req_valid = 1'b0;
        invalidated = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic check_mem(string tag);
        int bad = -1;
        drv_checks++;
        for (int i = 0; i < 512; i++) if (bad < 0 && fb[i] !== ref_fb[i]) bad = i;
        if (bad >= 0) begin
            drv_fails++;
            $display("FAIL %s memory at byte %0d: actual %02h expected %02h", tag, bad, fb[bad], ref_fb[bad]);
        end
    endtask

    task automatic fill(int col, int x, int y, int w, int h, bit bad, string tag, int linger);
        int nb = int'(cfg_bpp) * w;
        if (bad) begin
            exp_done(1, 1, tag);
        end else begin
            for (int r = 0; r < h; r++)
                for (int i = 0; i < nb; i++)
                    ref_fb[int'(cfg_bpp) * x + STRIDE * (y + r) + i] = 8'(col >> (8 * (i % int'(cfg_bpp))));
            exp_done(0, (nb == 0 || h == 0) ? 2 : 2 + nb + 2 * nb * (h - 1), tag);
            pend.push_back('{x, y, w, h});
        end
        do_op(0, col, x, y, 0, 0, w, h, 1'b0, linger);
        check_mem(tag);
    endtask

    task automatic copy(int sx, int sy, int x, int y, int w, int h, bit bad, string tag);
        int nb = int'(cfg_bpp) * w;
        logic [7:0] tmp [0:511];
        if (bad) begin
            exp_done(1, 1, tag);
        end else begin
            for (int r = 0; r < h; r++)
                for (int i = 0; i < nb; i++)
                    tmp[r * nb + i] = ref_fb[int'(cfg_bpp) * sx + STRIDE * (sy + r) + i];
            for (int r = 0; r < h; r++)
                for (int i = 0; i < nb; i++)
                    ref_fb[int'(cfg_bpp) * x + STRIDE * (y + r) + i] = tmp[r * nb + i];
            exp_done(0, (nb == 0 || h == 0) ? 2 : 2 + 2 * nb * h, tag);
            pend.push_back('{x, y, w, h});
        end
        do_op(1, 0, x, y, sx, sy, w, h, 1'b0, 0);
        check_mem(tag);
    endtask

    task automatic update(int x, int y, int w, int h, bit bad, string tag);
        exp_done(0, 2, tag);
        if (bad) pend.push_back('{0, 0, SW, SH});
        else     pend.push_back('{x, y, w, h});
        do_op(2, 0, x, y, 0, 0, w, h, 1'b0, 0);
    endtask

    task automatic flush(bit inv, string tag);
        if (inv) begin
            exp_done(0, 0, tag);
        end else begin
            for (int j = 0; j < pend.size(); j++) exp_upd(pend[j], j, tag);
            exp_done(0, pend.size() + 1, tag);
        end
        pend.delete();
        do_op(3, 0, 0, 0, 0, 0, 0, 0, inv, 0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) ref_fb[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        drv_checks++;
        if (busy !== 1'b0 || done !== 1'b0 || upd_valid !== 1'b0 || mem_en !== 1'b0) begin
            drv_fails++;
            $display("FAIL R12 reset: actual busy=%b done=%b upd=%b en=%b expected 0 0 0 0",
                     busy, done, upd_valid, mem_en);
        end
        check_mem("R12_reset_mem");

        // R4 R3 fills at several pixel sizes; R12 request held while busy is ignored
        cfg_bpp = 3'd1; fill(32'h11223344, 1, 1, 3, 2, 1'b0, "R4_fill_bpp1_R12_linger", 3);
        cfg_bpp = 3'd3; fill(32'hAABBCCDD, 0, 2, 2, 3, 1'b0, "R4_fill_bpp3", 0);
        cfg_bpp = 3'd4; fill(32'h01020304, 4, 0, 4, 1, 1'b0, "R3_fill_bpp4", 0);

        // R5 copies, overlapping in each direction
        cfg_bpp = 3'd2;
        copy(0, 0, 5, 5, 2, 2, 1'b0, "R5_copy_disjoint");
        copy(1, 1, 1, 2, 3, 3, 1'b0, "R5_copy_down_overlap");
        copy(2, 3, 2, 1, 3, 3, 1'b0, "R5_copy_up_overlap");
        copy(0, 4, 2, 4, 4, 1, 1'b0, "R5_copy_right_overlap");

        // R1 rejections, R2 copy rejections
        fill(32'hFFFFFFFF, -1, 0, 2, 2, 1'b1, "R1_neg_x", 0);
        fill(32'hFFFFFFFF, 6, 0, 3, 1, 1'b1, "R1_x_plus_w", 0);
        fill(32'hFFFFFFFF, 0, 6, 1, 3, 1'b1, "R1_y_plus_h", 0);
        fill(32'hFFFFFFFF, 0, 0, 1, 1771, 1'b1, "R1_h_over_max", 0);
        copy(7, 7, 0, 0, 2, 2, 1'b1, "R2_src_bad");
        copy(0, 0, 0, 7, 2, 2, 1'b1, "R2_dst_bad");

        // R6 zero-sized copy still recorded
        copy(1, 1, 3, 3, 0, 2, 1'b0, "R6_zero_width");

        // R11 illegal pixel sizes
        cfg_bpp = 3'd0; fill(32'h55555555, 0, 0, 1, 1, 1'b1, "R11_bpp0", 0);
        cfg_bpp = 3'd5; copy(0, 0, 1, 1, 1, 1, 1'b1, "R11_bpp5");
        cfg_bpp = 3'd2;

        // R10 updates
        update(1, 2, 3, 4, 1'b0, "R10_update_ok");
        update(-1, 0, 2, 2, 1'b1, "R10_update_full");

        // R9 ordered drain, R6 entries from every success
        flush(1'b0, "R9_R6_flush_order");

        // R8 invalidated flush discards
        update(0, 0, 1, 1, 1'b0, "R8_pre1");
        update(2, 2, 1, 1, 1'b0, "R8_pre2");
        flush(1'b1, "R8_flush_invalid");
        flush(1'b0, "R8_flush_after_discard");

        // R7 wrap without full check
        for (int i = 0; i < 512; i++) update(i % 8, (i / 8) % 8, 1, 1, 1'b0, "R7_fill_ring");
        pend.delete();
        update(5, 6, 2, 1, 1'b0, "R7_wrap_entry");
        flush(1'b0, "R7_flush_after_wrap");

        repeat (4) @(negedge clk);
        drv_checks++;
        if (q.size() != 0) begin
            drv_fails++;
            $display("FAIL R12 pending results: actual %0d outstanding expected 0", q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures",
                 mon_checks + drv_checks, mon_fails + drv_fails);
        $finish;
    end
endmodule